// File: doc/BRIEF.md
# Receive Trigger, Character Timeout and DMA Ready Controller

This block sits beside the receive and transmit FIFOs of a serial port and turns their fill counts into the signals that the host side needs. It flags when the receive FIFO holds at least a selectable number of characters. It runs a timer that raises a timeout when received data has been waiting for four character times without the line or the host touching it. It drives the two active-low DMA request pins for receive and transmit, following one of two handshake styles.

The first handshake style is single-transfer: each pin follows the presence of data directly. The second is block transfer: each pin is set by one FIFO condition and released by another, and holds its state in between. The FIFO storage, the serial shifters and the baud generator are outside this block. The block takes fill counts, a bit-time tick, a strobe at the centre of each received stop bit, a host read strobe and a receive-FIFO clear, together with the format and mode settings.

Top module: `rxtx_ready_ctrl`

## Requirements
- R1: The receive threshold is chosen by `trig_sel_i`. In large mode (`big_fifo_i`=1) codes 0,1,2,3 give 1, 16, 32 and 56 characters. In small mode they give 1, 4, 8 and 14. With `fifo_en_i`=0 the threshold is 1.
- R2: `rx_avail_o` is 1 in the same cycle that `rx_count_i` is at or above the threshold, and 0 in any cycle in which it is below the threshold.
- R3: The number of bits in a character is 1 + data + parity + stop. Data is 5, 6, 7 or 8 for `word_len_i` codes 0 to 3. Parity is 1 when `parity_en_i` is set. Stop is 2 when `stop2_i` is set and 1 otherwise. With the FIFOs enabled and data present, `timeout_o` rises at the clock edge that samples the 4×bits-th `bit_tick_i` since the last restart.
- R4: A cycle with `stop_mid_i` or `rhr_rd_i` set restarts the timeout count from zero, and the tick in that same cycle is not counted.
- R5: `timeout_o` is never raised while `rx_count_i` is 0 or `fifo_en_i` is 0. It clears at the edge after a cycle with `rhr_rd_i`, `rx_clr_i`, an empty receive FIFO or disabled FIFOs.
- R6: With `fifo_en_i`=0 or `dma_mode_i`=0, `rxrdy_o` is 0 when `rx_count_i` is nonzero and 1 when it is zero.
- R7: With `fifo_en_i`=0 or `dma_mode_i`=0, `txrdy_o` is 0 when `tx_count_i` is zero and 1 when it is nonzero.
- R8: With `fifo_en_i`=1 and `dma_mode_i`=1, `rxrdy_o` goes to 0 once the count reaches the threshold or `timeout_o` is 1. It then stays 0 while data remains, even if the count drops below the threshold, and returns to 1 only when `rx_count_i` is 0.
- R9: With `fifo_en_i`=1 and `dma_mode_i`=1, `txrdy_o` is 1 when `tx_count_i` equals the capacity (64 in large mode, 16 in small mode) and 0 when `tx_count_i` is 0. At counts in between it keeps the value it last had at one of those two points.
- R10: After reset `timeout_o` is 0 and the two block-mode pin states are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFOs enabled |
| big_fifo_i | input | 1 | 1: large capacity mode, 0: small |
| dma_mode_i | input | 1 | 0: single-transfer, 1: block-transfer handshake |
| trig_sel_i | input | 2 | Receive threshold code |
| word_len_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | Parity bit present |
| stop2_i | input | 1 | Two stop bits |
| rx_count_i | input | 7 | Receive FIFO fill count |
| tx_count_i | input | 7 | Transmit FIFO fill count |
| bit_tick_i | input | 1 | One pulse per bit time |
| stop_mid_i | input | 1 | Centre of a received stop bit |
| rhr_rd_i | input | 1 | Host read of the receive holding register |
| rx_clr_i | input | 1 | Receive FIFO clear |
| rx_avail_o | output | 1 | Receive count at or above threshold |
| timeout_o | output | 1 | Character timeout |
| rxrdy_o | output | 1 | Receive DMA request, active low |
| txrdy_o | output | 1 | Transmit DMA request, active low |

## Verification
Directed sweeps step the receive count across every threshold in both capacity modes. This separates the eight level encodings and the at-or-above comparison from an off-by-one. Timeout runs use several word formats and stop exactly one tick short of the limit and then on it. Other runs insert stop-bit strobes, reads and clears mid-count, which tells a correct restart and clear apart from a free-running timer. Block-mode sequences fill past the threshold and then partially drain, showing the held pin state that the single-transfer mode lacks. A long random walk of counts, strobes and settings is then compared against the bench model on every clock.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
  localparam int unsigned MAX_CHAR_BITS = 12;

  function automatic int unsigned char_bits(logic [1:0] wl, logic par, logic stop2);
    return 1 + (5 + int'(wl)) + int'(par) + (stop2 ? 2 : 1);
  endfunction

  function automatic int unsigned trig_level(int unsigned cap, logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return cap / 4;
      2'd2:    return cap / 2;
      default: return (cap * 7) / 8;
    endcase
  endfunction
endpackage

// File: rtl/rx_trig_cmp.sv
module rx_trig_cmp import rdy_pkg::*; #(
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned SMALL_DEPTH = 16,
  localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          big_fifo_i,
  input  logic [1:0]    trig_sel_i,
  input  logic [CW-1:0] count_i,
  output logic          avail_o
);
  logic [CW-1:0] lvl_big, lvl_small, level;

  always_comb begin
    lvl_big   = CW'(trig_level(DEPTH, trig_sel_i));
    lvl_small = CW'(trig_level(SMALL_DEPTH, trig_sel_i));
    if (!fifo_en_i)      level = CW'(1);
    else if (big_fifo_i) level = lvl_big;
    else                 level = lvl_small;
    avail_o = (count_i >= level);
  end

  p_avail_nonempty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o |-> (count_i != '0));
  p_lvl_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CW'(1) && (!fifo_en_i || trig_sel_i == 2'd0)) |-> avail_o);
endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer import rdy_pkg::*; #(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned CHAR_TIMES = 4,
  localparam int unsigned CW        = $clog2(DEPTH + 1),
  localparam int unsigned TW        = $clog2(CHAR_TIMES * MAX_CHAR_BITS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic [1:0]    word_len_i,
  input  logic          parity_en_i,
  input  logic          stop2_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic          bit_tick_i,
  input  logic          stop_mid_i,
  input  logic          rhr_rd_i,
  input  logic          rx_clr_i,
  output logic          timeout_o
);
  logic [TW-1:0] tmr_q, limit;
  logic          drop, restart, timeout_q;

  always_comb begin
    limit   = TW'(CHAR_TIMES * char_bits(word_len_i, parity_en_i, stop2_i));
    drop    = rx_clr_i | rhr_rd_i | (rx_count_i == '0) | !fifo_en_i;
    restart = drop | stop_mid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q     <= '0;
      timeout_q <= 1'b0;
    end else begin
      if (restart)                         tmr_q <= '0;
      else if (bit_tick_i && tmr_q < limit) tmr_q <= tmr_q + 1'b1;

      if (drop)                                         timeout_q <= 1'b0;
      else if (bit_tick_i && !stop_mid_i && tmr_q == limit - 1'b1) timeout_q <= 1'b1;
    end
  end

  assign timeout_o = timeout_q;

  p_rise_needs_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($past(rx_count_i) != '0 && $past(fifo_en_i)));
  p_rise_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(bit_tick_i));
  p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rhr_rd_i || rx_clr_i) |=> !timeout_o);
  p_restart_no_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_mid_i |=> !$rose(timeout_o));
endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen #(
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned SMALL_DEPTH = 16,
  localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          big_fifo_i,
  input  logic          dma_mode_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic [CW-1:0] tx_count_i,
  input  logic          rx_avail_i,
  input  logic          timeout_i,
  output logic          rxrdy_o,
  output logic          txrdy_o
);
  logic          burst, rx_empty, tx_empty, tx_full;
  logic          rx_req_q, tx_hold_q;
  logic [CW-1:0] cap;

  always_comb begin
    burst    = fifo_en_i & dma_mode_i;
    cap      = big_fifo_i ? CW'(DEPTH) : CW'(SMALL_DEPTH);
    rx_empty = (rx_count_i == '0);
    tx_empty = (tx_count_i == '0);
    tx_full  = (tx_count_i == cap);
  end

  // block-mode pin states, tracked in either mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_req_q  <= 1'b0;
      tx_hold_q <= 1'b0;
    end else begin
      if (rx_empty)                     rx_req_q <= 1'b0;
      else if (rx_avail_i || timeout_i) rx_req_q <= 1'b1;

      if (tx_full)       tx_hold_q <= 1'b1;
      else if (tx_empty) tx_hold_q <= 1'b0;
    end
  end

  always_comb begin
    if (!burst) begin
      rxrdy_o = rx_empty;
      txrdy_o = !tx_empty;
    end else begin
      rxrdy_o = rx_empty | !(rx_req_q | rx_avail_i | timeout_i);
      txrdy_o = tx_full | (!tx_empty & tx_hold_q);
    end
  end

  p_rxrdy_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty |-> rxrdy_o);
  p_txrdy_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty |-> !txrdy_o);
  p_txrdy_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst && tx_full) |-> txrdy_o);
  p_rxrdy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst && !rxrdy_o && $stable(burst)) ##1 (burst && !rx_empty) |-> !rxrdy_o);
endmodule

// File: rtl/rxtx_ready_ctrl.sv
module rxtx_ready_ctrl #(
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned SMALL_DEPTH = 16,
  parameter int unsigned CHAR_TIMES  = 4,
  localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          big_fifo_i,
  input  logic          dma_mode_i,
  input  logic [1:0]    trig_sel_i,
  input  logic [1:0]    word_len_i,
  input  logic          parity_en_i,
  input  logic          stop2_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic [CW-1:0] tx_count_i,
  input  logic          bit_tick_i,
  input  logic          stop_mid_i,
  input  logic          rhr_rd_i,
  input  logic          rx_clr_i,
  output logic          rx_avail_o,
  output logic          timeout_o,
  output logic          rxrdy_o,
  output logic          txrdy_o
);
  rx_trig_cmp #(.DEPTH(DEPTH), .SMALL_DEPTH(SMALL_DEPTH)) i_trig (
    .clk_i, .rst_ni, .fifo_en_i, .big_fifo_i, .trig_sel_i,
    .count_i (rx_count_i),
    .avail_o (rx_avail_o)
  );

  rx_char_timer #(.DEPTH(DEPTH), .CHAR_TIMES(CHAR_TIMES)) i_timer (
    .clk_i, .rst_ni, .fifo_en_i, .word_len_i, .parity_en_i, .stop2_i,
    .rx_count_i, .bit_tick_i, .stop_mid_i, .rhr_rd_i, .rx_clr_i,
    .timeout_o
  );

  dma_ready_gen #(.DEPTH(DEPTH), .SMALL_DEPTH(SMALL_DEPTH)) i_dma (
    .clk_i, .rst_ni, .fifo_en_i, .big_fifo_i, .dma_mode_i,
    .rx_count_i, .tx_count_i,
    .rx_avail_i (rx_avail_o),
    .timeout_i  (timeout_o),
    .rxrdy_o, .txrdy_o
  );

  p_reset_clear_r10: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !timeout_o);
endmodule

// File: tb/test_rxtx_ready_ctrl.sv
module test_rxtx_ready_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fe = 0, big = 0, dma = 0, par = 0, st2 = 0;
  logic [1:0] trig = 0, wl = 0;
  logic [6:0] rxc = 0, txc = 0;
  logic tick = 0, smid = 0, rd = 0, clr = 0;
  logic avail, to, rxrdy, txrdy;
  int errors = 0, checks = 0;
  bit running = 0;

  always #5 clk = ~clk;

  rxtx_ready_ctrl i_rxtx_ready_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fe), .big_fifo_i(big), .dma_mode_i(dma),
    .trig_sel_i(trig), .word_len_i(wl), .parity_en_i(par), .stop2_i(st2),
    .rx_count_i(rxc), .tx_count_i(txc), .bit_tick_i(tick), .stop_mid_i(smid),
    .rhr_rd_i(rd), .rx_clr_i(clr), .rx_avail_o(avail), .timeout_o(to),
    .rxrdy_o(rxrdy), .txrdy_o(txrdy));

  // reference model
  int m_tmr; bit m_to, m_rxreq, m_txhold;

  function automatic int lvl();
    int cap = big ? 64 : 16;
    if (!fe) return 1;
    case (trig) 0: return 1; 1: return cap / 4; 2: return cap / 2; default: return cap * 7 / 8; endcase
  endfunction
  function automatic int lim();
    return 4 * (1 + 5 + int'(wl) + int'(par) + (st2 ? 2 : 1));
  endfunction
  function automatic bit e_avail(); return int'(rxc) >= lvl(); endfunction
  function automatic bit e_rxrdy();
    if (!fe || !dma) return rxc == 0;
    if (rxc == 0) return 1;
    return !(m_rxreq || e_avail() || m_to);
  endfunction
  function automatic bit e_txrdy();
    int cap = big ? 64 : 16;
    if (!fe || !dma) return txc != 0;
    if (int'(txc) == cap) return 1;
    if (txc == 0) return 0;
    return m_txhold;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmr <= 0; m_to <= 0; m_rxreq <= 0; m_txhold <= 0;
    end else begin
      if (clr || rd || smid || rxc == 0 || !fe) m_tmr <= 0;
      else if (tick && m_tmr < lim()) m_tmr <= m_tmr + 1;
      if (clr || rd || rxc == 0 || !fe) m_to <= 0;
      else if (tick && !smid && m_tmr == lim() - 1) m_to <= 1;
      if (rxc == 0) m_rxreq <= 0;
      else if (e_avail() || m_to) m_rxreq <= 1;
      if (int'(txc) == (big ? 64 : 16)) m_txhold <= 1;
      else if (txc == 0) m_txhold <= 0;
    end
  end

  task automatic chk(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (running) begin
    chk(avail, e_avail(), "R2 rx_avail");
    chk(to, m_to, "R3 timeout");
    chk(rxrdy, e_rxrdy(), (fe && dma) ? "R8 rxrdy" : "R6 rxrdy");
    chk(txrdy, e_txrdy(), (fe && dma) ? "R9 txrdy" : "R7 txrdy");
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask
  task automatic pulse_rd(); rd = 1; step(1); rd = 0; endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(2);
    chk(to, 0, "R10 reset timeout"); chk(rxrdy, 1, "R10 reset rxrdy"); chk(txrdy, 0, "R10 reset txrdy");
    rst_n = 1; running = 1; step(1);
    // R6 R7: FIFOs off
    rxc = 1; txc = 1; step(1);
    chk(rxrdy, 0, "R6 disabled data"); chk(txrdy, 1, "R7 disabled data");
    chk(avail, 1, "R1 disabled level 1");
    rxc = 0; txc = 0; step(1);
    chk(rxrdy, 1, "R6 disabled empty"); chk(txrdy, 0, "R7 disabled empty");
    // R1 R2 threshold sweep
    fe = 1;
    for (int b = 0; b < 2; b++) for (int s = 0; s < 4; s++) begin
      big = b[0]; trig = s[1:0];
      for (int c = 0; c <= (b ? 64 : 16); c++) begin rxc = c[6:0]; step(1); end
      rxc = 7'(lvl() - 1); step(1); chk(avail, lvl() == 1 ? 0 : 0, "R1 below level");
      rxc = 7'(lvl()); step(1); chk(avail, 1, "R1 at level");
      rxc = 0; step(1);
    end
    // R3 timeout lengths
    for (int f = 0; f < 4; f++) begin
      wl = f[1:0]; par = f[0]; st2 = f[1];
      rxc = 3; pulse_rd();
      tick = 1; step(lim() - 1); chk(to, 0, "R3 one tick short");
      step(1); chk(to, 1, "R3 at limit"); tick = 0;
      pulse_rd(); chk(to, 0, "R5 read clears");
    end
    // R4 restarts
    wl = 3; par = 0; st2 = 0; tick = 1;
    pulse_rd(); step(20); smid = 1; step(1); smid = 0;
    step(39); chk(to, 0, "R4 stop-mid restart");
    step(1); chk(to, 1, "R4 after restart");
    clr = 1; step(1); clr = 0; chk(to, 0, "R5 clear");
    rxc = 0; step(60); chk(to, 0, "R5 empty never");
    tick = 0;
    // R8 R9 block mode
    dma = 1; big = 1; trig = 1; rxc = 5; step(2); chk(rxrdy, 1, "R8 below level");
    rxc = 16; step(1); chk(rxrdy, 0, "R8 level reached");
    rxc = 3; step(3); chk(rxrdy, 0, "R8 held");
    rxc = 0; step(1); chk(rxrdy, 1, "R8 empty");
    txc = 30; step(1); chk(txrdy, 0, "R9 partial");
    txc = 64; step(1); chk(txrdy, 1, "R9 full");
    txc = 10; step(2); chk(txrdy, 1, "R9 held");
    txc = 0; step(1); chk(txrdy, 0, "R9 empty");
    rxc = 2; tick = 1; pulse_rd(); step(40); chk(rxrdy, 0, "R8 timeout");
    tick = 0;
    // random walk
    for (int i = 0; i < 6000; i++) begin
      int cap;
      if ($urandom_range(0, 199) == 0) begin
        fe = 1'($urandom); big = 1'($urandom); dma = 1'($urandom);
        trig = 2'($urandom); wl = 2'($urandom); par = 1'($urandom); st2 = 1'($urandom);
      end
      cap = big ? 64 : 16;
      if ($urandom_range(0, 2) == 0 && rxc < cap) rxc++;
      else if ($urandom_range(0, 5) == 0 && rxc > 0) rxc--;
      if (rxc > cap) rxc = 7'(cap);
      if ($urandom_range(0, 1) == 0 && txc < cap) txc++;
      else if ($urandom_range(0, 1) == 0 && txc > 0) txc--;
      if (txc > cap) txc = 7'(cap);
      tick = ($urandom_range(0, 1) == 0);
      smid = ($urandom_range(0, 60) == 0);
      rd   = ($urandom_range(0, 80) == 0);
      clr  = ($urandom_range(0, 400) == 0);
      if (clr) rxc = 0;
      step(1);
    end
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule